// File: doc/BRIEF.md
# Reset Mode Latch and Vector Fetch Sequencer

This block is the reset front end of a small 8-bit microcontroller core. While the active-high reset is held, it keeps sampling three mode-strap inputs. The last sampled value becomes the operating mode on the first clock edge that sees reset low. The mode then stays fixed until reset is asserted again.

On leaving reset, the block runs two single-cycle reads on a simple memory read port. The first read takes the high byte of the start address from the second-highest byte location. The second read takes the low byte from the topmost location. The block assembles both bytes into the program counter and then raises a one-cycle start-execution pulse. The interrupt mask is set by reset, so it is already set before execution begins.

The captured mode is visible on a small register read port, together with five live port input lines. A decoded flag marks the multiplexed-bus, partial-decode mode.

Top module: `rst_vec_seq`

## Requirements
- R1: While `rst` is high, `mode_o` takes the value of `strap_i` at every clock edge. A register read at address 0x03 returns `{mode_o[2:0], port_in_i[4:0]}`, with the mode in bits 7..5 and the port lines in bits 4..0.
- R2: After the first edge with `rst` low, `mode_o` holds its value, and changes on `strap_i` have no effect on it until `rst` is high again.
- R3: A register read at any address other than 0x03 returns 0x00.
- R4: In the cycle after the first edge with `rst` low, `mem_rd_o` is 1 and `mem_addr_o` is 0xFFFE. In the following cycle, `mem_rd_o` is 1 and `mem_addr_o` is 0xFFFF. After that, `mem_rd_o` is 0. Read data is taken at the clock edge that ends each strobe cycle.
- R5: From the cycle after the second read onward, `pc_o` equals `{byte read at 0xFFFE, byte read at 0xFFFF}`. After the read at 0xFFFE, `pc_o[15:8]` already holds that byte. `pc_o` reads 0 while in reset.
- R6: `imask_o` is 1 throughout reset and whenever `start_o` is high.
- R7: `start_o` is high for exactly one cycle, the cycle right after the read at 0xFFFF. It is low while `rst` is high and during both fetch cycles.
- R8: If `rst` rises during the fetch, `mem_rd_o` drops in that same cycle, no `start_o` pulse follows, and the straps are sampled again. The next release of reset runs the complete fetch from the start.
- R9: `mux_bus_o` is 1 exactly when the latched mode is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Mode-strap levels |
| port_in_i | input | 5 | Live port input lines, shown in the low bits of the control register |
| reg_addr_i | input | 8 | Register read address |
| reg_rdata_o | output | 8 | Register read data |
| mem_addr_o | output | 16 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | 8 | Memory read data, same cycle as strobe |
| pc_o | output | 16 | Program counter |
| imask_o | output | 1 | Interrupt mask flag |
| mode_o | output | 3 | Latched mode code |
| mux_bus_o | output | 1 | Multiplexed-bus / partial-decode mode flag |
| start_o | output | 1 | One-cycle start-execution pulse |

## Verification
The bench sweeps all eight strap codes against several vectors and port patterns. It flips the straps right after release, which catches a latch that keeps tracking the pins, and it checks that the bytes land in the right halves, which catches a swapped byte order or a one-cycle data skew. It asserts reset mid-fetch, which exposes a design that lets the strobe linger or fires a start pulse anyway. It also checks the register at a neighbouring address and the mode-6 flag for every code.

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
  parameter int DW = 8,
  parameter int MW = 3,
  parameter int RAW = 8,
  parameter logic [RAW-1:0] CTRL_ADDR = 8'h03,
  parameter logic [MW-1:0] MUX_MODE = 3'd6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MW-1:0]   strap_i,
  input  logic [DW-MW-1:0] port_in_i,
  input  logic [RAW-1:0]  reg_addr_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [2*DW-1:0] mem_addr_o,
  output logic            mem_rd_o,
  input  logic [DW-1:0]   mem_data_i,
  output logic [2*DW-1:0] pc_o,
  output logic            imask_o,
  output logic [MW-1:0]   mode_o,
  output logic            mux_bus_o,
  output logic            start_o
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] VEC_LO = '1;
  localparam logic [AW-1:0] VEC_HI = VEC_LO - AW'(1);

  typedef enum logic [2:0] {S_RST, S_FHI, S_FLO, S_GO, S_RUN} st_t;
  st_t st;
  logic [MW-1:0] mode_q;
  logic [AW-1:0] pc_q;
  logic          imask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_RST;
      mode_q  <= strap_i;
      pc_q    <= '0;
      imask_q <= 1'b1;
    end else begin
      unique case (st)
        S_RST: st <= S_FHI;
        S_FHI: begin
          pc_q[AW-1:DW] <= mem_data_i;
          st <= S_FLO;
        end
        S_FLO: begin
          pc_q[DW-1:0] <= mem_data_i;
          st <= S_GO;
        end
        S_GO:  st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  assign mem_rd_o    = !rst && (st == S_FHI || st == S_FLO);
  assign mem_addr_o  = (st == S_FLO) ? VEC_LO : VEC_HI;
  assign start_o     = !rst && (st == S_GO);
  assign pc_o        = pc_q;
  assign imask_o     = imask_q;
  assign mode_o      = mode_q;
  assign mux_bus_o   = (mode_q == MUX_MODE);
  assign reg_rdata_o = (reg_addr_i == CTRL_ADDR) ? {mode_q, port_in_i} : '0;
endmodule

// File: rtl/rst_vec_seq_chk.sv
module rst_vec_seq_chk #(
  parameter int DW = 8,
  parameter int MW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_rd_o,
  input logic [2*DW-1:0] mem_addr_o,
  input logic            start_o,
  input logic            imask_o,
  input logic [MW-1:0]   mode_o,
  input logic [2*DW-1:0] pc_o
);
  // R7
  start_in_reset_chk: assert property (@(posedge clk) rst |-> (!start_o && !mem_rd_o));
  // R8
  rd_gated_chk: assert property (@(posedge clk) mem_rd_o |-> !rst);
  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_o));
  // R4
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (mem_addr_o[2*DW-1:1] == '1));
  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R7
  start_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> ($past(mem_rd_o) && $past(mem_addr_o[0])));
  // R6
  mask_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> imask_o);
  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !mem_rd_o && !$past(mem_rd_o)) |-> $stable(pc_o));
endmodule

bind rst_vec_seq rst_vec_seq_chk #(.DW(DW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .start_o(start_o), .imask_o(imask_o), .mode_o(mode_o), .pc_o(pc_o)
);

// File: tb/test_rst_vec_seq.sv
module test_rst_vec_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] strap = 3'd0;
  logic [4:0] pin = 5'd0;
  logic [7:0] raddr = 8'h03;
  logic [7:0] rdata, mdata;
  logic [15:0] maddr, pc;
  logic mrd, imask, mux, start;
  logic [2:0] mode;
  logic [15:0] vec = 16'h0000;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign mdata = (maddr == 16'hFFFE) ? vec[15:8] : (maddr == 16'hFFFF) ? vec[7:0] : 8'hA5;

  rst_vec_seq i_rst_vec_seq (
    .clk(clk), .rst(rst), .strap_i(strap), .port_in_i(pin),
    .reg_addr_i(raddr), .reg_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_data_i(mdata),
    .pc_o(pc), .imask_o(imask), .mode_o(mode), .mux_bus_o(mux), .start_o(start)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic run_one(input logic [2:0] s, input logic [15:0] v, input logic [4:0] p);
    rst = 1'b1; strap = s; pin = p; vec = v; raddr = 8'h03;
    cyc(); cyc();
    chk(mode === s, "R1 mode", {29'd0, mode}, {29'd0, s});
    chk(rdata === {s, p}, "R1 reg", {24'd0, rdata}, {24'd0, s, p});
    chk(start === 1'b0 && mrd === 1'b0, "R7 reset", {30'd0, start, mrd}, 32'd0);
    chk(imask === 1'b1, "R6 reset", {31'd0, imask}, 32'd1);
    chk(pc === 16'h0, "R5 reset pc", {16'd0, pc}, 32'd0);
    raddr = 8'h02;
    #1 chk(rdata === 8'h00, "R3 addr02", {24'd0, rdata}, 32'd0);
    raddr = 8'h03;
    rst = 1'b0;
    cyc();
    chk(mrd === 1'b1 && maddr === 16'hFFFE, "R4 hi", {15'd0, mrd, maddr}, {15'd0, 1'b1, 16'hFFFE});
    chk(start === 1'b0, "R7 fetch hi", {31'd0, start}, 32'd0);
    strap = ~s;
    cyc();
    chk(mrd === 1'b1 && maddr === 16'hFFFF, "R4 lo", {15'd0, mrd, maddr}, {15'd0, 1'b1, 16'hFFFF});
    chk(pc[15:8] === v[15:8], "R5 hi byte", {24'd0, pc[15:8]}, {24'd0, v[15:8]});
    chk(start === 1'b0, "R7 fetch lo", {31'd0, start}, 32'd0);
    cyc();
    chk(start === 1'b1, "R7 pulse", {31'd0, start}, 32'd1);
    chk(mrd === 1'b0, "R4 done", {31'd0, mrd}, 32'd0);
    chk(pc === v, "R5 pc", {16'd0, pc}, {16'd0, v});
    chk(imask === 1'b1, "R6 start", {31'd0, imask}, 32'd1);
    cyc();
    chk(start === 1'b0, "R7 one cycle", {31'd0, start}, 32'd0);
    chk(mode === s, "R2 frozen", {29'd0, mode}, {29'd0, s});
    chk(rdata[7:5] === s, "R2 reg", {29'd0, rdata[7:5]}, {29'd0, s});
    chk(mux === (s == 3'd6), "R9 mux", {31'd0, mux}, {31'd0, s == 3'd6});
    cyc();
    chk(pc === v && mrd === 1'b0, "R5 hold", {15'd0, mrd, pc}, {16'd0, v});
  endtask

  task automatic abort_at(input int n, input logic [2:0] s1, input logic [2:0] s2);
    rst = 1'b1; strap = s1; vec = 16'hC3E1;
    cyc(); cyc();
    rst = 1'b0;
    for (int i = 0; i < n; i++) cyc();
    chk(mrd === 1'b1, "R8 in fetch", {31'd0, mrd}, 32'd1);
    rst = 1'b1; strap = s2;
    #1 chk(mrd === 1'b0, "R8 strobe drop", {31'd0, mrd}, 32'd0);
    cyc();
    chk(start === 1'b0 && mrd === 1'b0, "R8 no start", {30'd0, start, mrd}, 32'd0);
    chk(mode === s2, "R8 recapture", {29'd0, mode}, {29'd0, s2});
    cyc();
    chk(start === 1'b0, "R8 still quiet", {31'd0, start}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        run_one(3'(s), 16'(16'h1234 * (s * 4 + k + 1)) ^ 16'h0F0F, 5'((s * 5 + k * 7) & 31));
    abort_at(1, 3'd2, 3'd5);
    run_one(3'd6, 16'h8001, 5'h15);
    abort_at(2, 3'd7, 3'd6);
    run_one(3'd1, 16'hFE7C, 5'h0A);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule